// File: doc/BRIEF.md
# Multicycle Shared-Resource Datapath

This block is the register-transfer half of a small 32-bit load/store processor that runs each instruction as a series of short steps. One memory port serves both instruction fetch and data access. One ALU computes the next sequential PC, the branch target and the execute result. Because values must survive from one step to the next, they are held in staging registers that software cannot see. These are the instruction register, two operand latches, an ALU result latch and a memory data latch. The block also holds the 32-entry register file.

The block makes no decisions of its own. A separate sequencer drives every steering select, write enable and ALU function on each cycle. The datapath returns to the sequencer the opcode and function fields of the held instruction and a zero flag taken from the ALU result.

The external memory presents read data for the address driven in the same cycle, and it commits writes on the clock edge. The reset input is asserted asynchronously and released synchronously inside the block, two clock edges after it deasserts.

Top module: `mcdp_datapath`

## Requirements
- R1: After reset the PC and all staging registers read zero. With `ctl_iord`=0, `mem_addr` is 0, and `opcode`, `funct` and `mem_wdata` are 0.
- R2: When `ctl_ir_wr`=1, the instruction register captures `mem_rdata` on the edge; otherwise it holds. The PC changes only when `ctl_pc_wr`=1, or when `ctl_pc_wr_cond`=1 and `zero`=1. With `ctl_pc_src`=0 it loads the live ALU output, so operand A select = PC with B select = 4 and add gives PC+4.
- R3: The operand latches load every cycle, with no enable, from the register file at the fields [25:21] (first operand) and [20:16] (second operand). `mem_wdata` is the second operand latch.
- R4: The ALU result latch loads the ALU output every cycle. With A select = PC and B select = 3, add yields PC plus the sign-extended field [15:0] shifted left by two.
- R5: `ctl_src_a` 0 selects the PC and 1 selects the first operand latch. `ctl_src_b` selects as follows: 0 is the second operand latch, 1 is constant 4, 2 is sign-extended [15:0], and 3 is that value shifted left by two. `ctl_alu_op` selects the function: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 nor, 6 signed less-than, 7 unsigned less-than. The less-than results are 1 or 0.
- R6: `zero` is 1 exactly when the live ALU output is all zeros. A conditional PC write with `ctl_pc_src`=1 loads the ALU result latch, which holds the target computed in the previous step. This happens only when A minus B is zero.
- R7: `mem_addr` is the PC when `ctl_iord`=0 and the ALU result latch when it is 1. `mem_we` follows `ctl_mem_wr`.
- R8: The memory data latch captures `mem_rdata` every cycle. The write-back data is that latch when `ctl_mem_to_reg`=1 and the ALU result latch when it is 0. The destination is field [20:16] when `ctl_reg_dst`=0 and [15:11] when it is 1.
- R9: Register 0 always reads zero, and writes to it are discarded.
- R10: `opcode` shows instruction register bits [31:26] and `funct` shows bits [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ctl_pc_wr | input | 1 | Unconditional PC write |
| ctl_pc_wr_cond | input | 1 | PC write qualified by zero |
| ctl_pc_src | input | 1 | PC source: 0 ALU output, 1 ALU result latch |
| ctl_iord | input | 1 | Memory address: 0 PC, 1 ALU result latch |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_ir_wr | input | 1 | Instruction register load enable |
| ctl_reg_wr | input | 1 | Register file write enable |
| ctl_reg_dst | input | 1 | Destination field: 0 [20:16], 1 [15:11] |
| ctl_mem_to_reg | input | 1 | Write-back: 0 ALU result latch, 1 memory data latch |
| ctl_src_a | input | 1 | ALU input A: 0 PC, 1 first operand latch |
| ctl_src_b | input | 2 | ALU input B select |
| ctl_alu_op | input | 3 | ALU function |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | Held instruction bits [31:26] |
| funct | output | 6 | Held instruction bits [5:0] |
| zero | output | 1 | ALU output is zero |

## Verification
Two functions overlap on a single branch-resolve cycle. The ALU is busy forming A minus B for the compare, while the PC takes the target that the same ALU left in the result latch one step earlier. The bench provokes this with a forward branch that is taken, a branch that falls through and a backward taken branch. It judges each case by the zero flag sampled mid-cycle and by the address the next fetch presents. The fetch step is the other shared cycle, where the instruction capture and the PC+4 update happen together. Every fetch checks the address presented, and every following fetch confirms the increment.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_NOR  = 3'd5,
    ALU_SLT  = 3'd6,
    ALU_SLTU = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG    = 2'd0,
    SRCB_FOUR   = 2'd1,
    SRCB_IMM    = 2'd2,
    SRCB_IMM_SH = 2'd3
  } srcb_e;

endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y,
  output logic           zero
);

  logic lt_s;
  logic lt_u;

  always_comb begin
    lt_s = ($signed(a) < $signed(b));
    lt_u = (a < b);
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLT:  y = {{(W-1){1'b0}}, lt_s};
      ALU_SLTU: y = {{(W-1){1'b0}}, lt_u};
      default:  y = a + b;
    endcase
    zero = (y == '0);
  end

  // R6: a subtract flags zero exactly for equal operands
  always_comb begin
    if (op == ALU_SUB) begin
      p_sub_zero_r6: assert (zero == (a == b));
    end
  end

endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 1; i < DEPTH; i++) begin
      if (we && (waddr == AW'(i))) begin
        regs[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
  end

endmodule

// File: rtl/mcdp_datapath.sv
module mcdp_datapath
  import mcdp_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_pc_wr,
  input  logic         ctl_pc_wr_cond,
  input  logic         ctl_pc_src,
  input  logic         ctl_iord,
  input  logic         ctl_mem_wr,
  input  logic         ctl_ir_wr,
  input  logic         ctl_reg_wr,
  input  logic         ctl_reg_dst,
  input  logic         ctl_mem_to_reg,
  input  logic         ctl_src_a,
  input  logic [1:0]   ctl_src_b,
  input  logic [2:0]   ctl_alu_op,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic [5:0]   opcode,
  output logic [5:0]   funct,
  output logic         zero
);

  localparam int RAW    = $clog2(NREG);
  localparam int IMM_W  = 16;
  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [W-1:0]   pc_q, pc_d, ir_q, ir_d;
  logic [W-1:0]   a_q, b_q, alu_q, mdr_q;
  logic [W-1:0]   rf_a, rf_b, alu_in_a, alu_in_b, alu_y, imm_sx, wb_data;
  logic [RAW-1:0] wb_addr;
  logic           pc_en;

  mcdp_regfile #(.W(W), .DEPTH(NREG)) u_rf (
    .clk     (clk),
    .we      (ctl_reg_wr),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (ir_q[RS_LSB +: RAW]),
    .raddr_b (ir_q[RT_LSB +: RAW]),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  mcdp_alu #(.W(W)) u_alu (
    .op   (alu_op_e'(ctl_alu_op)),
    .a    (alu_in_a),
    .b    (alu_in_b),
    .y    (alu_y),
    .zero (zero)
  );

  // next-state and steering
  always_comb begin
    imm_sx   = {{(W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    alu_in_a = ctl_src_a ? a_q : pc_q;
    unique case (srcb_e'(ctl_src_b))
      SRCB_REG:    alu_in_b = b_q;
      SRCB_FOUR:   alu_in_b = W'(4);
      SRCB_IMM:    alu_in_b = imm_sx;
      SRCB_IMM_SH: alu_in_b = imm_sx << 2;
      default:     alu_in_b = b_q;
    endcase
    mem_addr = ctl_iord ? alu_q : pc_q;
    wb_addr  = ctl_reg_dst ? ir_q[RD_LSB +: RAW] : ir_q[RT_LSB +: RAW];
    wb_data  = ctl_mem_to_reg ? mdr_q : alu_q;
    pc_en    = ctl_pc_wr | (ctl_pc_wr_cond & zero);
    pc_d     = ctl_pc_src ? alu_q : alu_y;
    ir_d     = ctl_ir_wr ? mem_rdata : ir_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
      mdr_q <= '0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      ir_q  <= ir_d;
      a_q   <= rf_a;
      b_q   <= rf_b;
      alu_q <= alu_y;
      mdr_q <= mem_rdata;
    end
  end

  assign mem_wdata = b_q;
  assign mem_we    = ctl_mem_wr;
  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];

  // R2: PC holds without a write request
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctl_pc_wr && !ctl_pc_wr_cond) |=> $stable(pc_q));

  // R2: instruction capture and hold
  p_ir_load_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctl_ir_wr |=> (ir_q == $past(mem_rdata)));
  p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl_ir_wr |=> $stable(ir_q));

  // R6: taken branch lands on the previously latched target
  p_branch_tgt_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_pc_wr_cond && !ctl_pc_wr && ctl_pc_src && zero) |=> (pc_q == $past(alu_q)));

  // R8: memory data latch follows the read port
  p_mdr_load_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctl_iord |=> (mdr_q == $past(mem_rdata)));

  // R9: register 0 always presents zero
  p_r0_zero_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ir_q[RS_LSB +: RAW] == '0) |=> (a_q == '0));

endmodule

// File: tb/test_mcdp_datapath.sv
module test_mcdp_datapath;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
                         OP_XOR = 3'd4, OP_NOR = 3'd5, OP_SLT = 3'd6, OP_SLTU = 3'd7;

  logic clk, rst_n;
  logic ctl_pc_wr, ctl_pc_wr_cond, ctl_pc_src, ctl_iord, ctl_mem_wr, ctl_ir_wr;
  logic ctl_reg_wr, ctl_reg_dst, ctl_mem_to_reg, ctl_src_a;
  logic [1:0] ctl_src_b;
  logic [2:0] ctl_alu_op;
  logic [W-1:0] mem_rdata, mem_addr, mem_wdata;
  logic mem_we, zero;
  logic [5:0] opcode, funct;

  mcdp_datapath i_mcdp_datapath (
    .clk(clk), .rst_n(rst_n),
    .ctl_pc_wr(ctl_pc_wr), .ctl_pc_wr_cond(ctl_pc_wr_cond), .ctl_pc_src(ctl_pc_src),
    .ctl_iord(ctl_iord), .ctl_mem_wr(ctl_mem_wr), .ctl_ir_wr(ctl_ir_wr),
    .ctl_reg_wr(ctl_reg_wr), .ctl_reg_dst(ctl_reg_dst), .ctl_mem_to_reg(ctl_mem_to_reg),
    .ctl_src_a(ctl_src_a), .ctl_src_b(ctl_src_b), .ctl_alu_op(ctl_alu_op),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .opcode(opcode), .funct(funct), .zero(zero)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: instructions below 0x200, data from 0x200
  logic [W-1:0] imem [128];
  logic [W-1:0] dmem [128];
  assign mem_rdata = mem_addr[9] ? dmem[mem_addr[8:2]] : imem[mem_addr[8:2]];
  always @(posedge clk) if (mem_we && mem_addr[9]) dmem[mem_addr[8:2]] <= mem_wdata;

  typedef struct packed { logic [31:0] addr; logic [31:0] data; logic [7:0] req; } sb_item_t;
  sb_item_t sb_q [$];
  sb_item_t mon_item;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_pc;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every store must match the next expected item
  always @(posedge clk) begin
    if (mem_we) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected store actual=%h/%h expected=none", mem_addr, mem_wdata);
      end else begin
        mon_item = sb_q.pop_front();
        if (mem_addr !== mon_item.addr || mem_wdata !== mon_item.data) begin
          errors++;
          $display("FAIL R%0d store actual=%h/%h expected=%h/%h", mon_item.req,
                   mem_addr, mem_wdata, mon_item.addr, mon_item.data);
        end
      end
    end
  end

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic idle();
    ctl_pc_wr = 0; ctl_pc_wr_cond = 0; ctl_pc_src = 0; ctl_iord = 0; ctl_mem_wr = 0;
    ctl_ir_wr = 0; ctl_reg_wr = 0; ctl_reg_dst = 0; ctl_mem_to_reg = 0; ctl_src_a = 0;
    ctl_src_b = 2'd0; ctl_alu_op = OP_ADD;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_fetch(logic [31:0] instr);
    imem[exp_pc[8:2]] = instr;
    idle();
    ctl_ir_wr = 1; ctl_src_b = 2'd1; ctl_pc_wr = 1;
    #1;
    chk("R7 fetch address", mem_addr, exp_pc);
    tick();
    exp_pc = exp_pc + 32'd4;
    chk("R10 opcode", {26'd0, opcode}, {26'd0, instr[31:26]});
    chk("R10 funct", {26'd0, funct}, {26'd0, instr[5:0]});
  endtask

  task automatic do_decode();
    ctl_src_b = 2'd3;
    tick();
  endtask

  task automatic run_imm(logic [4:0] rs, logic [4:0] rt, logic [15:0] imm, logic [2:0] op);
    do_fetch(enc_i(6'h08, rs, rt, imm));
    do_decode();
    ctl_src_a = 1; ctl_src_b = 2'd2; ctl_alu_op = op; tick();
    ctl_reg_wr = 1; ctl_reg_dst = 0; tick();
  endtask

  task automatic run_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [2:0] op, logic [5:0] fn);
    do_fetch(enc_r(rs, rt, rd, fn));
    do_decode();
    ctl_src_a = 1; ctl_src_b = 2'd0; ctl_alu_op = op; tick();
    ctl_reg_wr = 1; ctl_reg_dst = 1; tick();
  endtask

  task automatic run_sw(logic [4:0] rs, logic [4:0] rt, logic [15:0] imm,
                        logic [31:0] ea, logic [31:0] ed, logic [7:0] req);
    sb_item_t it;
    do_fetch(enc_i(6'h2b, rs, rt, imm));
    do_decode();
    ctl_src_a = 1; ctl_src_b = 2'd2; tick();
    it.addr = ea; it.data = ed; it.req = req;
    sb_q.push_back(it);
    ctl_iord = 1; ctl_mem_wr = 1; tick();
  endtask

  task automatic run_lw(logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    do_fetch(enc_i(6'h23, rs, rt, imm));
    do_decode();
    ctl_src_a = 1; ctl_src_b = 2'd2; tick();
    ctl_iord = 1; tick();
    ctl_reg_wr = 1; ctl_reg_dst = 0; ctl_mem_to_reg = 1; tick();
  endtask

  task automatic run_beq(logic [4:0] rs, logic [4:0] rt, logic [15:0] off, logic taken);
    logic [31:0] tgt;
    do_fetch(enc_i(6'h04, rs, rt, off));
    tgt = exp_pc + (sx(off) << 2);
    do_decode();
    ctl_src_a = 1; ctl_src_b = 2'd0; ctl_alu_op = OP_SUB;
    ctl_pc_wr_cond = 1; ctl_pc_src = 1;
    #1;
    chk("R6 zero flag", {31'd0, zero}, {31'd0, taken});
    tick();
    if (taken) exp_pc = tgt;
    #1;
    chk("R6 pc after branch", mem_addr, exp_pc);
  endtask

  initial begin
    rst_n = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    exp_pc = 32'd0;
    // R1: reset state
    chk("R1 pc", mem_addr, 32'd0);
    chk("R1 opcode", {26'd0, opcode}, 32'd0);
    chk("R1 funct", {26'd0, funct}, 32'd0);
    chk("R1 wdata", mem_wdata, 32'd0);
    chk("R1 mem_we", {31'd0, mem_we}, 32'd0);

    run_imm(5'd0, 5'd1, 16'h0008, OP_ADD);            // r1 = 8
    run_imm(5'd0, 5'd2, 16'hFFFD, OP_ADD);            // r2 = -3 (R5 sign extension)
    run_r(5'd1, 5'd2, 5'd3, OP_SUB, 6'h22);           // r3 = 11
    run_sw(5'd1, 5'd3, 16'h0300, 32'h308, 32'd11, 8'd3); // R3 / R7

    imem[7'h7C] = 32'hDEADBEEF;                       // word at 0x1F0
    run_lw(5'd1, 5'd4, 16'h01E8);                     // R8 load into r4
    run_sw(5'd0, 5'd4, 16'h0340, 32'h340, 32'hDEADBEEF, 8'd8);

    run_imm(5'd1, 5'd0, 16'h0007, OP_ADD);            // R9 write to r0 dropped
    run_sw(5'd0, 5'd0, 16'h0344, 32'h344, 32'd0, 8'd9);

    run_r(5'd2, 5'd1, 5'd5, OP_SLT, 6'h2a);           // R5 signed -3 < 8
    run_sw(5'd0, 5'd5, 16'h0348, 32'h348, 32'd1, 8'd5);
    run_r(5'd2, 5'd1, 5'd6, OP_SLTU, 6'h2b);          // R5 unsigned compare
    run_sw(5'd0, 5'd6, 16'h034C, 32'h34C, 32'd0, 8'd5);
    run_r(5'd1, 5'd2, 5'd7, OP_NOR, 6'h27);
    run_sw(5'd0, 5'd7, 16'h0350, 32'h350, 32'h00000002, 8'd5);
    run_r(5'd1, 5'd2, 5'd8, OP_XOR, 6'h26);
    run_sw(5'd0, 5'd8, 16'h0354, 32'h354, 32'hFFFFFFF5, 8'd5);
    run_imm(5'd2, 5'd9, 16'h00F0, OP_AND);
    run_sw(5'd0, 5'd9, 16'h0358, 32'h358, 32'h000000F0, 8'd5);
    run_r(5'd1, 5'd2, 5'd10, OP_OR, 6'h25);
    run_sw(5'd0, 5'd10, 16'h035C, 32'h35C, 32'hFFFFFFFD, 8'd5);

    run_beq(5'd1, 5'd1, 16'h0003, 1'b1);              // R4 / R6 forward taken
    run_beq(5'd1, 5'd2, 16'h0005, 1'b0);              // R6 not taken
    run_beq(5'd0, 5'd0, 16'hFFFE, 1'b1);              // R6 backward taken
    run_sw(5'd0, 5'd3, 16'h0360, 32'h360, 32'd11, 8'd2); // R2 fetch after branch

    repeat (2) @(negedge clk);
    chk("R7 all stores seen", sb_q.size(), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule